// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block sits between the interrupt detectors of one UART channel and its register interface. Seven detectors each present a pending flag, and software supplies a matching enable bit for each. Every clock the block picks the highest-ranked source that is both pending and enabled. It registers an 8-bit identification code that reports that source, and it drives an interrupt request line that is high while any enabled source is pending. Two status bits, which report whether the receive FIFO is on, ride in the top of the code and take no part in the arbitration.

Reading the code can clear some sources. A read that finds the transmit-empty, special-character or flow-change source reported sends a one-cycle clear pulse back to that source's detector. The controller is a two-state machine. In state `S_TRACK`, the code and request registers follow the arbiter on every clock. A read strobe in `S_TRACK` freezes the code for that clock and takes the transition *read-accept* into `S_ACK`. `S_ACK` lasts one clock. In it the controller emits the clear pulse for the source that was reported, if that source is clearable, and holds the code. The transition *ack-done* then returns unconditionally to `S_TRACK`. Reset enters `S_TRACK`.

Top module: `uart_int_ident`

## Requirements
- R1: A pending, enabled line-status error (source index 0) outranks every other source and is reported as code bits [5:0] = 6'h06.
- R2: A pending, enabled receive time-out (index 1) is reported as 6'h0C. It wins over receive-data-ready when both are pending.
- R3: Receive-data-ready (index 2) is reported as 6'h04 when no higher source is active.
- R4: Transmit-holding-empty (index 3) is reported as 6'h02 when no higher source is active.
- R5: Modem-status change (index 4) is reported as 6'h00 when no higher source is active.
- R6: Received Xoff or special character (index 5) is reported as 6'h10 when no higher source is active.
- R7: A CTS/RTS change to inactive (index 6) has the lowest rank and is reported as 6'h20.
- R8: With no source both pending and enabled, bits [5:0] are 6'h01 and the request output is low. A pending source whose enable is 0 has no effect. During and after reset the code is 8'h01, the request is low and no clear is asserted.
- R9: Bit 0 is 0 exactly when the request output is 1. The code and the request reflect the inputs one clock after they are applied.
- R10: A read while code 6'h02 is shown makes clr_thr high for exactly the next clock. The code is held through the read clock and the clear clock.
- R11: A read while 6'h10 or 6'h20 is shown pulses clr_spc or clr_flow in the same way. A read of any other code pulses no clear. At most one clear is high at a time.
- R12: Code bits [7:6] take the fifo status input one clock later in every controller state, whatever the arbitration does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | 7 | Pending flags, index 0 = line status error .. 6 = flow change |
| src_en | input | 7 | Enable bits, same indexing |
| fifo_stat | input | STAT_W | FIFO-enabled status shown in bits [7:6] |
| id_rd | input | 1 | One-cycle read strobe of the identification code |
| id_code | output | 8 | Registered identification code |
| irq | output | 1 | Interrupt request, high while an enabled source pends |
| clr_thr | output | 1 | Clear pulse to the transmit-empty detector |
| clr_spc | output | 1 | Clear pulse to the special-character detector |
| clr_flow | output | 1 | Clear pulse to the flow-change detector |

## Verification
The bench builds the block with its defaults: seven sources and a two-bit status field, which together fill the 8-bit code. Seven sources put every rank and every code value within reach, along with the tie inside rank two and the masking of a pending source by its enable. With a two-bit status field, a status change during `S_ACK` can be seen in the same code that the read freezes.

// File: rtl/uid_pkg.sv
package uid_pkg;

    localparam int N_SRC = 7;

    localparam int IX_LSE  = 0;
    localparam int IX_RTO  = 1;
    localparam int IX_RDR  = 2;
    localparam int IX_THR  = 3;
    localparam int IX_MSC  = 4;
    localparam int IX_SPC  = 5;
    localparam int IX_FLOW = 6;

    localparam logic [5:0] CODE_NONE = 6'h01;

    typedef enum logic [0:0] {
        S_TRACK = 1'b0,
        S_ACK   = 1'b1
    } ctl_state_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_THR  = 2'd1,
        TGT_SPC  = 2'd2,
        TGT_FLOW = 2'd3
    } clr_tgt_t;

    function automatic logic [5:0] src_code(input int idx);
        case (idx)
            IX_LSE:  return 6'h06;
            IX_RTO:  return 6'h0C;
            IX_RDR:  return 6'h04;
            IX_THR:  return 6'h02;
            IX_MSC:  return 6'h00;
            IX_SPC:  return 6'h10;
            IX_FLOW: return 6'h20;
            default: return CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uid_arbiter.sv
module uid_arbiter #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] act,
    output logic [N-1:0] grant
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_rank
            assign grant[i]  = act[i] & ~seen[i];
            assign seen[i+1] = seen[i] | act[i];
        end
    endgenerate

    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act != '0) |-> (grant != '0));

endmodule

// File: rtl/uid_encoder.sv
module uid_encoder
    import uid_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic [N-1:0] grant,
    output logic [5:0]   code,
    output clr_tgt_t     tgt
);

    always_comb begin
        code = (grant == '0) ? CODE_NONE : 6'h00;
        tgt  = TGT_NONE;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                code = code | src_code(i);
                if (i == IX_THR)  tgt = TGT_THR;
                if (i == IX_SPC)  tgt = TGT_SPC;
                if (i == IX_FLOW) tgt = TGT_FLOW;
            end
        end
    end

endmodule

// File: rtl/uid_ctrl.sv
module uid_ctrl
    import uid_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     id_rd,
    input  clr_tgt_t shown_tgt,
    output logic     load,
    output logic     clr_thr,
    output logic     clr_spc,
    output logic     clr_flow
);

    ctl_state_t state_q, state_d;
    clr_tgt_t   tgt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_TRACK: if (id_rd) state_d = S_ACK;
            S_ACK:   state_d = S_TRACK;
            default: state_d = S_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_TRACK;
            tgt_q   <= TGT_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == S_TRACK && id_rd) tgt_q <= shown_tgt;
        end
    end

    always_comb begin
        load     = 1'b0;
        clr_thr  = 1'b0;
        clr_spc  = 1'b0;
        clr_flow = 1'b0;
        unique case (state_q)
            S_TRACK: load = !id_rd;
            S_ACK: begin
                clr_thr  = (tgt_q == TGT_THR);
                clr_spc  = (tgt_q == TGT_SPC);
                clr_flow = (tgt_q == TGT_FLOW);
            end
            default: load = 1'b0;
        endcase
    end

    p_clr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_thr, clr_spc, clr_flow}));

    p_clr_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_thr || clr_spc || clr_flow) |-> $past(id_rd));

    p_clr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_thr || clr_spc || clr_flow) |=> !(clr_thr || clr_spc || clr_flow));

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uid_pkg::*;
#(
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_pend,
    input  logic [N_SRC-1:0]  src_en,
    input  logic [STAT_W-1:0] fifo_stat,
    input  logic              id_rd,
    output logic [7:0]        id_code,
    output logic              irq,
    output logic              clr_thr,
    output logic              clr_spc,
    output logic              clr_flow
);

    localparam int CODE_W = 8 - STAT_W;

    logic [N_SRC-1:0]  act;
    logic [N_SRC-1:0]  grant;
    logic [5:0]        win_code;
    clr_tgt_t          win_tgt;
    logic              load;

    logic [CODE_W-1:0] code_q;
    logic [STAT_W-1:0] stat_q;
    logic              irq_q;
    clr_tgt_t          shown_q;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_mask
            assign act[i] = src_pend[i] & src_en[i];
        end
    endgenerate

    uid_arbiter #(.N(N_SRC)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .grant (grant)
    );

    uid_encoder #(.N(N_SRC)) u_enc (
        .grant (grant),
        .code  (win_code),
        .tgt   (win_tgt)
    );

    uid_ctrl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_rd     (id_rd),
        .shown_tgt (shown_q),
        .load      (load),
        .clr_thr   (clr_thr),
        .clr_spc   (clr_spc),
        .clr_flow  (clr_flow)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= CODE_W'(CODE_NONE);
            irq_q   <= 1'b0;
            shown_q <= TGT_NONE;
            stat_q  <= '0;
        end else begin
            stat_q <= fifo_stat;
            if (load) begin
                code_q  <= CODE_W'(win_code);
                irq_q   <= (act != '0);
                shown_q <= win_tgt;
            end
        end
    end

    assign id_code = {stat_q, code_q};
    assign irq     = irq_q;

    p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !id_code[0]);

    p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (id_code[5:0] == CODE_NONE));

    p_hold_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_thr |-> (id_code[5:0] == 6'h02) && $stable(id_code[5:0]));

    p_spc_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_spc |-> (id_code[5:0] == 6'h10));

endmodule

// File: tb/sim_uart_int_ident.sv
module sim_uart_int_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_pend = '0;
    logic [6:0] src_en = '0;
    logic [1:0] fifo_stat = '0;
    logic       id_rd = 1'b0;
    logic [7:0] id_code;
    logic       irq;
    logic       clr_thr, clr_spc, clr_flow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_int_ident #(.STAT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
        .fifo_stat(fifo_stat), .id_rd(id_rd), .id_code(id_code), .irq(irq),
        .clr_thr(clr_thr), .clr_spc(clr_spc), .clr_flow(clr_flow)
    );

    // {req index, enable, pending, expected code[5:0], expected irq}
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {4'd8,  7'h7F, 7'h00, 6'h01, 1'b0}, // R8 nothing pending
        {4'd1,  7'h7F, 7'h7F, 6'h06, 1'b1}, // R1 all pending
        {4'd2,  7'h7F, 7'h7E, 6'h0C, 1'b1}, // R2
        {4'd2,  7'h7F, 7'h06, 6'h0C, 1'b1}, // R2 tie in rank two
        {4'd3,  7'h7F, 7'h04, 6'h04, 1'b1}, // R3
        {4'd4,  7'h7F, 7'h78, 6'h02, 1'b1}, // R4
        {4'd5,  7'h7F, 7'h70, 6'h00, 1'b1}, // R5
        {4'd6,  7'h7F, 7'h60, 6'h10, 1'b1}, // R6
        {4'd7,  7'h7F, 7'h40, 6'h20, 1'b1}, // R7
        {4'd8,  7'h00, 7'h7F, 6'h01, 1'b0}, // R8 all masked
        {4'd9,  7'h7E, 7'h03, 6'h0C, 1'b1}, // R9 top masked
        {4'd8,  7'h40, 7'h3F, 6'h01, 1'b0}  // R8 masked pendings
    };

    function automatic string rq(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_and_check(input logic [6:0] pend, input logic [5:0] code,
                                  input logic [2:0] exp_clr, input string req);
        src_en = 7'h7F;
        src_pend = pend;
        @(negedge clk);
        chk(req, {26'd0, id_code[5:0]}, {26'd0, code});
        id_rd = 1'b1;
        src_pend = '0;
        @(negedge clk);
        id_rd = 1'b0;
        chk(req, {29'd0, clr_thr, clr_spc, clr_flow}, {29'd0, exp_clr});
        chk(req, {26'd0, id_code[5:0]}, {26'd0, code});
        @(negedge clk);
        chk(req, {29'd0, clr_thr, clr_spc, clr_flow}, 32'd0);
        chk(req, {26'd0, id_code[5:0]}, {26'd0, code});
        @(negedge clk);
        chk(req, {26'd0, id_code[5:0]}, 32'h01);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        src_pend = 7'h7F;
        src_en = 7'h7F;
        fifo_stat = 2'b11;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", {24'd0, id_code}, 32'h01);
        chk("R8", {29'd0, irq, clr_thr, clr_spc | clr_flow}, 32'd0);
        src_pend = '0;
        fifo_stat = '0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            src_en = VEC[i][20:14];
            src_pend = VEC[i][13:7];
            @(negedge clk);
            chk(rq(int'(VEC[i][24:21])), {26'd0, id_code[5:0]}, {26'd0, VEC[i][6:1]});
            chk(rq(int'(VEC[i][24:21])), {31'd0, irq}, {31'd0, VEC[i][0]});
            chk("R9", {31'd0, irq}, {31'd0, ~id_code[0]});
        end

        // R9 one-clock latency: inputs change, output unchanged before the edge
        src_en = 7'h7F;
        src_pend = 7'h01;
        @(negedge clk);
        src_pend = 7'h10;
        #1;
        chk("R9", {26'd0, id_code[5:0]}, 32'h06);
        @(negedge clk);
        chk("R9", {26'd0, id_code[5:0]}, 32'h00);

        // R10 / R11 read-clear behaviour
        read_and_check(7'h08, 6'h02, 3'b100, "R10");
        read_and_check(7'h20, 6'h10, 3'b010, "R11");
        read_and_check(7'h40, 6'h20, 3'b001, "R11");
        read_and_check(7'h04, 6'h04, 3'b000, "R11");

        // R12 status bits follow in every state, including the ack state
        fifo_stat = 2'b10;
        @(negedge clk);
        chk("R12", {30'd0, id_code[7:6]}, 32'h2);
        src_pend = 7'h08;
        @(negedge clk);
        id_rd = 1'b1;
        fifo_stat = 2'b01;
        @(negedge clk);
        id_rd = 1'b0;
        fifo_stat = 2'b11;
        chk("R12", {30'd0, id_code[7:6]}, 32'h1);
        @(negedge clk);
        chk("R12", {30'd0, id_code[7:6]}, 32'h3);
        chk("R12", {26'd0, id_code[5:0]}, 32'h02);
        src_pend = '0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule